// File: doc/BRIEF.md
# Serially Configured Clock Fan-Out Gate

This block takes one reference clock and produces six gated output pairs plus a feedback clock. Each output pair, and the feedback clock, has its own enable bit. The enable bits live in two configuration bytes, which a host loads over a two-wire SMBus slave port using a block write. A mode input chooses how the second output of each pair behaves. It is either an in-phase copy of the reference or its inverse. An active-low power-down input forces every clock output low at once.

The serial port is sampled by an internal system clock. Both bus lines pass through a two-flop synchronizer before start, stop and clock edges are detected. Enables reach the clock paths through latches. A true output, or the feedback output, can change its enable only while the reference is low. An inverted complement output can change its enable only while the reference is high. This way a clock pulse that is already high is never cut short.

Top module: `clkfan_gate_ctrl`

## Requirements
- R1: After reset, all six pairs and the feedback output are enabled. Configuration byte 6 holds 8'h1F and byte 7 holds 8'hFF.
- R2: The port acknowledges only the address byte 7'b1101001 followed by a write bit of 0. Any other address, and a read bit of 1, gets no acknowledge. The rest of that transfer has no effect on any output.
- R3: A transfer is address, command byte, count byte, then data bytes. Every byte of an addressed write is acknowledged by pulling the data line low for the ninth clock. Data byte k, shifted in most significant bit first, is written to configuration byte k.
- R4: Data bytes beyond the count given in the count byte are acknowledged but not stored.
- R5: The feedback output is enabled by byte 6 bit 4. Pair 5 is enabled by byte 6 bit 3, and pair 4 by byte 6 bit 1.
- R6: In byte 7, bit 0 enables pair 0, bit 2 enables pair 1, bit 5 enables pair 2 and bit 6 enables pair 3.
- R7: Bytes 0 to 5 are accepted and have no effect on any output. The reserved bits of bytes 6 and 7 (byte 6 bits 7,6,5,2,0 and byte 7 bits 7,4,3,1) also have no effect on any output.
- R8: An output whose enable bit is 0 is held low. This applies to both outputs of a disabled pair.
- R9: While the power-down input is 0, every pair output and the feedback output are low, whatever the enable bits hold.
- R10: With the mode input at 0, both outputs of a pair copy the reference in phase. With it at 1, the second output is the inverse of the reference.
- R11: A stop or start condition abandons the transfer under way. Data bytes already acknowledged stay stored, and a partly received byte is discarded.
- R12: A true output that is high while its enable goes to 0 stays high until the reference falls. It stays low from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Internal clock that samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| smb_scl | input | 1 | Serial bus clock line |
| smb_sda | input | 1 | Serial bus data line as seen on the wire |
| smb_sda_pull | output | 1 | 1 pulls the data line low (acknowledge) |
| ref_clk | input | 1 | Reference clock to be fanned out |
| pd_n | input | 1 | 0 forces all clock outputs low |
| inv_sel | input | 1 | 1 inverts the second output of each pair |
| clk_t | output | 6 | First output of each pair |
| clk_c | output | 6 | Second output of each pair |
| fb_clk | output | 1 | Feedback clock output |

## Verification
On every system clock cycle the assertions check three things. Power-down holds all thirteen outputs low. In in-phase mode the two outputs of each pair agree. The acknowledge pull changes only while the serial clock is low. The bench sweeps walking-one and walking-zero patterns through both configuration bytes, in both modes, and compares every output in both reference phases. It checks the bit mapping, the count limit, rejected addresses and the abort on a stop. It also holds the reference high across an enable change to show a pulse is not cut short. These cases depend on complete transfers and on the reference phase, and only the bench scenarios can show them.

// File: rtl/clkfan_pkg.sv
`timescale 1ns/1ps
package clkfan_pkg;
  localparam int NPAIR = 6;
  localparam logic [6:0] DEV_ADDR = 7'b1101001;
  localparam logic [7:0] CFG_A_IDX = 8'd6;
  localparam logic [7:0] CFG_B_IDX = 8'd7;
  localparam logic [7:0] CFG_A_RST = 8'h1F;
  localparam logic [7:0] CFG_B_RST = 8'hFF;
  localparam int FB_BIT = 4;

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK, RX_SKIP} rx_state_t;

  // pair enables from the two configuration bytes, pair 5 in the top bit
  function automatic logic [NPAIR-1:0] pair_map(input logic [7:0] cfg_a, input logic [7:0] cfg_b);
    pair_map = {cfg_a[3], cfg_a[1], cfg_b[6], cfg_b[5], cfg_b[2], cfg_b[0]};
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_val,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_d, sda_d;
  logic            scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC-2:0], sda_in};
      scl_d  <= scl_sh[SYNC-1];
      sda_d  <= sda_sh[SYNC-1];
    end
  end

  assign scl_s     = scl_sh[SYNC-1];
  assign sda_s     = sda_sh[SYNC-1];
  assign sda_val   = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_blkwr_rx.sv
`timescale 1ns/1ps
module smb_blkwr_rx import clkfan_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_val,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  output logic       ack_pull,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data
);
  rx_state_t  st_q, st_n;
  logic [3:0] bc_q, bc_n;
  logic [7:0] sh_q, sh_n;
  logic [7:0] bn_q, bn_n;
  logic [7:0] cnt_q, cnt_n;
  logic       ack_q, ack_n;

  always_comb begin
    st_n    = st_q;
    bc_n    = bc_q;
    sh_n    = sh_q;
    bn_n    = bn_q;
    cnt_n   = cnt_q;
    ack_n   = ack_q;
    wr_en   = 1'b0;
    wr_idx  = bn_q - 8'd3;
    wr_data = sh_q;
    if (bus_start) begin
      st_n  = RX_BITS;
      bc_n  = 4'd0;
      bn_n  = 8'd0;
      ack_n = 1'b0;
    end else if (bus_stop) begin
      st_n  = RX_IDLE;
      ack_n = 1'b0;
    end else begin
      case (st_q)
        RX_BITS: begin
          if (scl_rise && bc_q != 4'd8) begin
            sh_n = {sh_q[6:0], sda_val};
            bc_n = bc_q + 4'd1;
          end else if (scl_fall && bc_q == 4'd8) begin
            if (bn_q == 8'd0 && sh_q != {DEV_ADDR, 1'b0}) begin
              st_n = RX_SKIP;
            end else begin
              st_n  = RX_ACK;
              ack_n = 1'b1;
              if (bn_q == 8'd2) cnt_n = sh_q;
              if (bn_q >= 8'd3 && (bn_q - 8'd3) < cnt_q) wr_en = 1'b1;
            end
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            ack_n = 1'b0;
            st_n  = RX_BITS;
            bc_n  = 4'd0;
            if (bn_q != 8'hFF) bn_n = bn_q + 8'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      bc_q  <= 4'd0;
      sh_q  <= 8'd0;
      bn_q  <= 8'd0;
      cnt_q <= 8'd0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      bc_q  <= bc_n;
      sh_q  <= sh_n;
      bn_q  <= bn_n;
      cnt_q <= cnt_n;
      ack_q <= ack_n;
    end
  end

  assign ack_pull = ack_q;
endmodule

// File: rtl/clkfan_cfg_regs.sv
`timescale 1ns/1ps
module clkfan_cfg_regs import clkfan_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  output logic [7:0] cfg_a,
  output logic [7:0] cfg_b
);
  logic a_we, b_we;

  assign a_we = wr_en && (wr_idx == CFG_A_IDX);
  assign b_we = wr_en && (wr_idx == CFG_B_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a <= CFG_A_RST;
      cfg_b <= CFG_B_RST;
    end else begin
      if (a_we) cfg_a <= wr_data;
      if (b_we) cfg_b <= wr_data;
    end
  end
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell (
  input  logic ref_clk,
  input  logic en,
  input  logic pd_n,
  input  logic inv,
  output logic gclk
);
  logic en_lo, en_hi;

  // enable for the true phase settles while the reference is low
  always_latch begin
    if (!ref_clk) en_lo <= en;
  end

  // enable for the inverted phase settles while the reference is high
  always_latch begin
    if (ref_clk) en_hi <= en;
  end

  assign gclk = pd_n & (inv ? (~ref_clk & en_hi) : (ref_clk & en_lo));
endmodule

// File: rtl/clkfan_gate_ctrl.sv
`timescale 1ns/1ps
module clkfan_gate_ctrl import clkfan_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic             smb_scl,
  input  logic             smb_sda,
  output logic             smb_sda_pull,
  input  logic             ref_clk,
  input  logic             pd_n,
  input  logic             inv_sel,
  output logic [NPAIR-1:0] clk_t,
  output logic [NPAIR-1:0] clk_c,
  output logic             fb_clk
);
  logic [1:0]       rst_sh;
  logic             rst_core_n;
  logic             sda_val, scl_rise, scl_fall, bus_start, bus_stop;
  logic             wr_en;
  logic [7:0]       wr_idx, wr_data;
  logic [7:0]       cfg_a, cfg_b;
  logic [NPAIR-1:0] pair_en;
  logic             fb_en;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_core_n = rst_sh[1];

  smb_line_sync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk(sys_clk), .rst_n(rst_core_n), .scl_in(smb_scl), .sda_in(smb_sda),
    .sda_val(sda_val), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  smb_blkwr_rx u_rx (
    .clk(sys_clk), .rst_n(rst_core_n), .sda_val(sda_val), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .ack_pull(smb_sda_pull), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  clkfan_cfg_regs u_regs (
    .clk(sys_clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cfg_a(cfg_a), .cfg_b(cfg_b)
  );

  assign pair_en = pair_map(cfg_a, cfg_b);
  assign fb_en   = cfg_a[FB_BIT];

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    clk_gate_cell u_t (
      .ref_clk(ref_clk), .en(pair_en[i]), .pd_n(pd_n), .inv(1'b0), .gclk(clk_t[i])
    );
    clk_gate_cell u_c (
      .ref_clk(ref_clk), .en(pair_en[i]), .pd_n(pd_n), .inv(inv_sel), .gclk(clk_c[i])
    );
  end

  clk_gate_cell u_fb (
    .ref_clk(ref_clk), .en(fb_en), .pd_n(pd_n), .inv(1'b0), .gclk(fb_clk)
  );
endmodule

// File: rtl/clkfan_gate_chk.sv
`timescale 1ns/1ps
module clkfan_gate_chk #(
  parameter int NP = 6
) (
  input logic          sys_clk,
  input logic          rst_n,
  input logic          smb_scl,
  input logic          smb_sda_pull,
  input logic          pd_n,
  input logic          inv_sel,
  input logic [NP-1:0] clk_t,
  input logic [NP-1:0] clk_c,
  input logic          fb_clk
);
  p_pd_all_low_r9: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !pd_n |-> (clk_t == '0 && clk_c == '0 && !fb_clk));

  p_inphase_pairs_r10: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !inv_sel |-> (clk_t == clk_c));

  p_ack_starts_scl_low_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(smb_sda_pull) |-> !smb_scl);

  p_ack_steady_scl_high_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (smb_scl && $past(smb_scl)) |-> $stable(smb_sda_pull));
endmodule

bind clkfan_gate_ctrl clkfan_gate_chk #(.NP(6)) u_chk (
  .sys_clk(sys_clk), .rst_n(rst_n), .smb_scl(smb_scl), .smb_sda_pull(smb_sda_pull),
  .pd_n(pd_n), .inv_sel(inv_sel), .clk_t(clk_t), .clk_c(clk_c), .fb_clk(fb_clk)
);

// File: tb/sim_clkfan_gate_ctrl.sv
`timescale 1ns/1ps
module sim_clkfan_gate_ctrl;
  logic sys_clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic ref_clk = 1'b0, ref_hold = 1'b0, pd_n = 1'b1, inv_sel = 1'b0;
  logic sda_pull, fb;
  logic [5:0] ct, cc;
  wire  sda_bus = sda_m & ~sda_pull;
  int   vecs = 0, errs = 0;
  logic done = 1'b0;
  logic [7:0] m_a = 8'h1F, m_b = 8'hFF;
  localparam logic [6:0] GOOD = 7'b1101001;

  always #10 sys_clk = ~sys_clk;
  always begin #15; if (!ref_hold) ref_clk = ~ref_clk; end

  clkfan_gate_ctrl u0 (
    .sys_clk(sys_clk), .rst_n(rst_n), .smb_scl(scl), .smb_sda(sda_bus),
    .smb_sda_pull(sda_pull), .ref_clk(ref_clk), .pd_n(pd_n), .inv_sel(inv_sel),
    .clk_t(ct), .clk_c(cc), .fb_clk(fb)
  );

  task automatic cmp(input string tag, input logic [12:0] act, input logic [12:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // expected outputs for one reference phase, from the enable bit map of R5/R6
  task automatic check_phase(input string tag, input logic hi);
    logic [5:0] en, et, ec;
    logic ef;
    en = {m_a[3], m_a[1], m_b[6], m_b[5], m_b[2], m_b[0]} & {6{pd_n}};
    ef = m_a[4] & pd_n & hi;
    et = hi ? en : 6'd0;
    ec = inv_sel ? (hi ? 6'd0 : en) : et;
    cmp(tag, {ct, cc, fb}, {et, ec, ef});
  endtask

  task automatic check_all(input string tag);
    repeat (2) @(posedge ref_clk);
    #5 check_phase(tag, 1'b1);
    @(negedge ref_clk);
    #5 check_phase(tag, 1'b0);
  endtask

  task automatic smb_start();
    sda_m = 1'b1; scl = 1'b1; #200;
    sda_m = 1'b0; #200;
    scl = 1'b0;
  endtask

  task automatic smb_stop();
    scl = 1'b0; sda_m = 1'b0; #200;
    scl = 1'b1; #200;
    sda_m = 1'b1; #200;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; #200;
    scl = 1'b1; #200;
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; #200;
    scl = 1'b1; #100;
    ack = ~sda_bus; #100;
    scl = 1'b0;
  endtask

  // block write; data byte k sits at data[8k+:8]
  task automatic blk_write(input logic [6:0] addr, input logic rw, input logic [7:0] cnt,
                           input logic [63:0] data, input int nb, output int acks);
    logic a;
    acks = 0;
    smb_start();
    send_byte({addr, rw}, a);
    if (a) begin
      acks++;
      send_byte(8'h00, a); acks += int'(a);
      send_byte(cnt, a);   acks += int'(a);
      for (int k = 0; k < nb; k++) begin
        send_byte(data[8*k +: 8], a);
        acks += int'(a);
      end
    end
    smb_stop();
    if (addr == GOOD && !rw) begin
      for (int k = 0; k < nb; k++) begin
        if (k < int'(cnt) && k == 6) m_a = data[55:48];
        if (k < int'(cnt) && k == 7) m_b = data[63:56];
      end
    end
  endtask

  task automatic ack_check(input string tag, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: acks %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge sys_clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int acks;
    logic [7:0] p;
    logic a;
    #95 rst_n = 1'b1;
    repeat (5) @(posedge sys_clk);
    check_all("R1 reset enables");

    // R3 R5 R6 R7 R10: walking one and walking zero through both bytes, junk in bytes 0-5
    for (int i = 0; i < 16; i++) begin
      p = (i < 8) ? (8'h01 << i) : ~(8'h01 << (i - 8));
      blk_write(GOOD, 1'b0, 8'd8, {p, ~p, 8'h5A, 8'hA5, 8'h3C, 8'hC3, 8'h0F, p}, 8, acks);
      ack_check("R3 every byte acked", acks, 11);
      inv_sel = 1'b0;
      check_all("R5 R6 R7 R10 in-phase map");
      inv_sel = 1'b1;
      check_all("R5 R6 R7 R10 inverted map");
    end
    inv_sel = 1'b0;

    // R8: all disabled
    blk_write(GOOD, 1'b0, 8'd8, 64'h0000_FFFF_FFFF_FFFF, 8, acks);
    check_all("R8 all disabled low");
    inv_sel = 1'b1;
    check_all("R8 all disabled low inverted");

    // R9: power-down overrides enables in both modes
    blk_write(GOOD, 1'b0, 8'd8, 64'hFFFF_0000_0000_0000, 8, acks);
    for (int s = 0; s < 2; s++) begin
      inv_sel = s[0];
      pd_n = 1'b0;
      check_all("R9 power-down");
      pd_n = 1'b1;
      check_all("R9 power-down released");
    end
    inv_sel = 1'b0;

    // R2: wrong addresses and read bit are not acknowledged and change nothing
    blk_write(7'b1101000, 1'b0, 8'd8, 64'h0, 8, acks);
    ack_check("R2 wrong address nack", acks, 0);
    blk_write(7'b0101001, 1'b0, 8'd8, 64'h0, 8, acks);
    ack_check("R2 wrong address nack", acks, 0);
    blk_write(GOOD, 1'b1, 8'd8, 64'h0, 8, acks);
    ack_check("R2 read bit nack", acks, 0);
    check_all("R2 outputs unchanged");

    // R4: count of 7 keeps byte 7 from being stored
    blk_write(GOOD, 1'b0, 8'd7, 64'h00_12_00000000_0000, 8, acks);
    ack_check("R4 extra byte still acked", acks, 11);
    check_all("R4 byte beyond count ignored");

    // R11: stop inside byte 7 keeps byte 6, discards partial byte 7
    m_b = 8'hFF;
    blk_write(GOOD, 1'b0, 8'd8, 64'hFF_FF_0000_0000_0000, 8, acks);
    smb_start();
    send_byte({GOOD, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'd8, a);
    for (int k = 0; k < 6; k++) send_byte(8'h00, a);
    send_byte(8'h0A, a);
    m_a = 8'h0A;
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    smb_stop();
    check_all("R11 abort keeps acked byte, drops partial");

    // R12: enable dropped while reference held high does not cut the pulse
    blk_write(GOOD, 1'b0, 8'd8, 64'hFF_FF_0000_0000_0000, 8, acks);
    check_all("R12 setup all enabled");
    @(posedge ref_clk);
    ref_hold = 1'b1;
    blk_write(GOOD, 1'b0, 8'd8, 64'h0, 8, acks);
    #5 cmp("R12 high pulse kept", {ct, cc, fb}, {6'h3F, 6'h3F, 1'b1});
    ref_hold = 1'b0;
    @(negedge ref_clk);
    #5 cmp("R12 low after fall", {ct, cc, fb}, 13'h0);
    @(posedge ref_clk);
    #5 cmp("R12 stays low", {ct, cc, fb}, 13'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule